// File: doc/BRIEF.md
# Register-or-Input Output Multiplexer

This block drives a 4-bit output group from one of two sources. The first source is an external 4-bit input. The second is the low nibble of a small 5-bit configuration register. A select input chooses between them. The top bit of the register drives a separate single-bit output through a hold stage. That output follows the register while select is low and freezes while select is high, so host writes made during that time cannot disturb it.

An active-low override input pulls every output low, but only while select is low. A synchronous host port writes and reads the register. It stands in for a serial slave. A write-protect input can block all writes through that port. Reset puts every register bit at zero.

Top module: `cfgmux_top`

## Requirements
- R1: While `rst` is high and on the first sample after it, `cfg_rd` reads 0x00. With `sel` low and `ovr_n` high, `grp_out` is 0 and `solo_out` is 0.
- R2: With `sel` low and `ovr_n` high, `grp_out` equals register bits [3:0], as seen on `cfg_rd[3:0]`.
- R3: With `sel` high, `grp_out` equals `ext_in` whatever the state of `ovr_n`.
- R4: With `sel` low and `ovr_n` high, `solo_out` equals register bit [4] in the same cycle (transparent).
- R5: Each rising edge sampled with `sel` low loads the hold stage with the value register bit [4] has after that edge. While `sel` is high, `solo_out` shows the hold stage. So a write made while `sel` is high reaches `solo_out` only once `sel` returns low, and a write on the last low edge is carried into the held value.
- R6: With `ovr_n` low and `sel` low, `grp_out` is 0 and `solo_out` is 0. The register still accepts writes.
- R7: With `ovr_n` low and `sel` high, override has no effect: `grp_out` follows `ext_in` and `solo_out` keeps the held value.
- R8: A rising edge with `wr_en` high and `wp` high leaves the register unchanged.
- R9: A rising edge with `wr_en` high and `wp` low stores `wr_data[4:0]` into the register. `wr_data[7:5]` is discarded.
- R10: `cfg_rd` always returns the 5-bit register in bits [4:0], with bits [7:5] zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | 0 selects register nibble, 1 selects external input |
| ovr_n | input | 1 | Active-low override forcing outputs low while sel is 0 |
| wp | input | 1 | Write protect, 1 blocks host writes |
| ext_in | input | 4 | External data for the output group |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data, bits [4:0] used |
| cfg_rd | output | 8 | Register readback, zero-extended |
| grp_out | output | 4 | Multiplexed output group |
| solo_out | output | 1 | Register bit [4] through the hold stage |

## Verification
The cycle of interest is a host write that lands on the same rising edge at which the hold stage takes its last sample before `sel` goes high. The bench provokes this by writing bit [4] = 1 with `sel` low and raising `sel` on the very next cycle. It then checks that `solo_out` shows the newly written value and not the old one. A second collision is a write under override with `sel` low. The outputs must stay low while `cfg_rd` shows the new value, and the new nibble must appear once override is released.

// File: rtl/cfgmux_pkg.sv
package cfgmux_pkg;

    localparam int DEF_GRP_W = 4;
    localparam int DEF_RD_W  = 8;

    typedef enum logic {
        SRC_REG = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    // Override only bites while the register is the selected source.
    function automatic logic force_low(input src_e src, input logic ovr_n);
        return (src == SRC_REG) && !ovr_n;
    endfunction

    function automatic logic wr_allowed(input logic wr_en, input logic wp);
        return wr_en && !wp;
    endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store #(
    parameter int GRP_W = 4,
    parameter int RD_W  = 8,
    localparam int CFG_W = GRP_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wp,
    input  logic [RD_W-1:0]  wr_data,
    output logic [CFG_W-1:0] cfg_q,
    output logic [CFG_W-1:0] cfg_d,
    output logic [RD_W-1:0]  rd_data
);
    import cfgmux_pkg::*;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_allowed(wr_en, wp))
            cfg_d = wr_data[CFG_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cfg_d;
    end

    generate
        if (RD_W > CFG_W) begin : g_pad
            assign rd_data = {{(RD_W-CFG_W){1'b0}}, cfg_q};
        end else begin : g_nopad
            assign rd_data = cfg_q[RD_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/hold_stage.sv
module hold_stage (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic d,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= 1'b0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/out_select.sv
module out_select #(
    parameter int GRP_W = 4
) (
    input  cfgmux_pkg::src_e  src,
    input  logic              ovr_n,
    input  logic [GRP_W-1:0]  reg_grp,
    input  logic              reg_solo,
    input  logic [GRP_W-1:0]  ext_in,
    input  logic              held_solo,
    output logic [GRP_W-1:0]  grp_out,
    output logic              solo_out
);
    import cfgmux_pkg::*;

    logic kill;
    assign kill = force_low(src, ovr_n);

    generate
        for (genvar i = 0; i < GRP_W; i++) begin : g_bit
            always_comb begin
                if (src == SRC_EXT) grp_out[i] = ext_in[i];
                else                grp_out[i] = reg_grp[i] & ~kill;
            end
        end
    endgenerate

    always_comb begin
        if (src == SRC_EXT) solo_out = held_solo;
        else                solo_out = reg_solo & ~kill;
    end

endmodule

// File: rtl/cfgmux_top.sv
module cfgmux_top #(
    parameter int GRP_W = cfgmux_pkg::DEF_GRP_W,
    parameter int RD_W  = cfgmux_pkg::DEF_RD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             ovr_n,
    input  logic             wp,
    input  logic [GRP_W-1:0] ext_in,
    input  logic             wr_en,
    input  logic [RD_W-1:0]  wr_data,
    output logic [RD_W-1:0]  cfg_rd,
    output logic [GRP_W-1:0] grp_out,
    output logic             solo_out
);
    import cfgmux_pkg::*;

    localparam int CFG_W = GRP_W + 1;

    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cfg_d;
    logic             held;
    src_e             src;

    assign src = src_e'(sel);

    cfg_store #(.GRP_W(GRP_W), .RD_W(RD_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wp      (wp),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .cfg_d   (cfg_d),
        .rd_data (cfg_rd)
    );

    // Samples the post-edge value of the top bit on every register-source cycle.
    hold_stage u_hold (
        .clk     (clk),
        .rst     (rst),
        .capture (src == SRC_REG),
        .d       (cfg_d[CFG_W-1]),
        .q       (held)
    );

    out_select #(.GRP_W(GRP_W)) u_sel (
        .src       (src),
        .ovr_n     (ovr_n),
        .reg_grp   (cfg_q[GRP_W-1:0]),
        .reg_solo  (cfg_q[CFG_W-1]),
        .ext_in    (ext_in),
        .held_solo (held),
        .grp_out   (grp_out),
        .solo_out  (solo_out)
    );

endmodule

// File: rtl/cfgmux_top_chk.sv
module cfgmux_top_chk #(
    parameter int GRP_W = 4,
    parameter int RD_W  = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             sel,
    input logic             ovr_n,
    input logic             wp,
    input logic [GRP_W-1:0] ext_in,
    input logic             wr_en,
    input logic [RD_W-1:0]  wr_data,
    input logic [RD_W-1:0]  cfg_rd,
    input logic [GRP_W-1:0] grp_out,
    input logic             solo_out
);
    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (cfg_rd == '0));

    assert_reg_nibble_R2: assert property (@(posedge clk) disable iff (rst)
        (!sel && ovr_n) |-> (grp_out == cfg_rd[GRP_W-1:0]));

    assert_ext_path_R3: assert property (@(posedge clk) disable iff (rst)
        sel |-> (grp_out == ext_in));

    assert_solo_transparent_R4: assert property (@(posedge clk) disable iff (rst)
        (!sel && ovr_n) |-> (solo_out == cfg_rd[GRP_W]));

    assert_solo_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        (sel && $past(sel)) |-> $stable(solo_out));

    assert_override_low_R6: assert property (@(posedge clk) disable iff (rst)
        (!sel && !ovr_n) |-> (grp_out == '0 && !solo_out));

    assert_protect_hold_R8: assert property (@(posedge clk) disable iff (rst)
        wp |=> $stable(cfg_rd));

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wp) |=> (cfg_rd[GRP_W:0] == $past(wr_data[GRP_W:0])));

    assert_pad_zero_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_rd[RD_W-1:GRP_W+1] == '0);

endmodule

bind cfgmux_top cfgmux_top_chk #(.GRP_W(GRP_W), .RD_W(RD_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .ovr_n    (ovr_n),
    .wp       (wp),
    .ext_in   (ext_in),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .cfg_rd   (cfg_rd),
    .grp_out  (grp_out),
    .solo_out (solo_out)
);

// File: tb/cfgmux_top_test.sv
module cfgmux_top_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel = 1'b1;      // undriven inputs sit at their pulled-up value
    logic       ovr_n = 1'b1;
    logic       wp = 1'b1;
    logic [3:0] ext_in = 4'hF;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cfg_rd;
    logic [3:0] grp_out;
    logic       solo_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cfgmux_top uut (
        .clk(clk), .rst(rst), .sel(sel), .ovr_n(ovr_n), .wp(wp),
        .ext_in(ext_in), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_rd(cfg_rd), .grp_out(grp_out), .solo_out(solo_out)
    );

    typedef struct packed {
        logic [7:0] req;
        logic       s;
        logic       o;
        logic       p;
        logic       we;
        logic [7:0] wd;
        logic [3:0] ex;
        logic [3:0] e_grp;
        logic       e_solo;
        logic [7:0] e_rd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'd9,  1'b0,1'b1,1'b0,1'b1, 8'hF5, 4'hF, 4'h5, 1'b1, 8'h15}, // R9 R2 R4: upper bits dropped
        '{8'd3,  1'b1,1'b1,1'b0,1'b0, 8'h00, 4'hA, 4'hA, 1'b1, 8'h15}, // R3
        '{8'd5,  1'b1,1'b1,1'b0,1'b1, 8'h0A, 4'h3, 4'h3, 1'b1, 8'h0A}, // R5 write while held
        '{8'd7,  1'b1,1'b0,1'b0,1'b0, 8'h00, 4'h6, 4'h6, 1'b1, 8'h0A}, // R7
        '{8'd4,  1'b0,1'b1,1'b0,1'b0, 8'h00, 4'h6, 4'hA, 1'b0, 8'h0A}, // R4 R5 released
        '{8'd8,  1'b0,1'b1,1'b1,1'b1, 8'h1F, 4'h6, 4'hA, 1'b0, 8'h0A}, // R8
        '{8'd6,  1'b0,1'b0,1'b0,1'b0, 8'h00, 4'h6, 4'h0, 1'b0, 8'h0A}, // R6
        '{8'd6,  1'b0,1'b0,1'b0,1'b1, 8'h13, 4'h6, 4'h0, 1'b0, 8'h13}, // R6 write under override
        '{8'd2,  1'b0,1'b1,1'b0,1'b0, 8'h00, 4'h6, 4'h3, 1'b1, 8'h13}, // R2
        '{8'd8,  1'b1,1'b1,1'b1,1'b1, 8'h00, 4'hC, 4'hC, 1'b1, 8'h13}, // R8 R3
        '{8'd10, 1'b0,1'b1,1'b0,1'b1, 8'hE0, 4'hC, 4'h0, 1'b0, 8'h00}, // R10 R9
        '{8'd5,  1'b1,1'b1,1'b0,1'b1, 8'h1E, 4'h9, 4'h9, 1'b0, 8'h1E}, // R5
        '{8'd7,  1'b1,1'b0,1'b0,1'b0, 8'h00, 4'h5, 4'h5, 1'b0, 8'h1E}, // R7
        '{8'd4,  1'b0,1'b1,1'b0,1'b0, 8'h00, 4'h5, 4'hE, 1'b1, 8'h1E}  // R4
    };

    task automatic check(input string tag, input logic [3:0] eg, input logic es, input logic [7:0] er);
        n_cmp += 3;
        if (grp_out !== eg) begin
            n_bad++;
            $display("FAIL %s grp_out actual=%h expected=%h", tag, grp_out, eg);
        end
        if (solo_out !== es) begin
            n_bad++;
            $display("FAIL %s solo_out actual=%b expected=%b", tag, solo_out, es);
        end
        if (cfg_rd !== er) begin
            n_bad++;
            $display("FAIL %s cfg_rd actual=%h expected=%h", tag, cfg_rd, er);
        end
    endtask

    task automatic drive(input logic s, input logic o, input logic p, input logic we,
                         input logic [7:0] wd, input logic [3:0] ex);
        sel = s; ovr_n = o; wp = p; wr_en = we; wr_data = wd; ext_in = ex;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=5000 cycles", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'hF);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 after reset", 4'h0, 1'b0, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].s, VECS[i].o, VECS[i].p, VECS[i].we, VECS[i].wd, VECS[i].ex);
            @(negedge clk);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].e_grp, VECS[i].e_solo, VECS[i].e_rd);
        end

        // R1: mid-run reset clears a nonzero register
        drive(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 4'h5);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", 4'h0, 1'b0, 8'h00);
        rst = 1'b0;

        // R5: write on the last low edge is carried into the held value
        drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 4'h5);
        @(negedge clk);
        check("R5 write edge", 4'h0, 1'b1, 8'h10);
        drive(1'b1, 1'b0, 1'b0, 1'b1, 8'h07, 4'h2);
        @(negedge clk);
        check("R5 held new bit", 4'h2, 1'b1, 8'h07);
        drive(1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 4'h2);
        @(negedge clk);
        check("R5 still held", 4'h2, 1'b1, 8'h07);
        drive(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 4'h2);
        @(negedge clk);
        check("R4 release", 4'h7, 1'b0, 8'h07);

        finish_run();
    end

endmodule